// File: doc/BRIEF.md
# ALU with Flag Generation

This block is the execute stage of a small 32-bit processor. Each cycle in which `issue` is high, it takes a 4-bit operation code, two 32-bit operands and a 4-bit branch-condition selector. It registers a 33-bit result and a five-flag status word. The first operand is the source value, or a zero-extended 12-bit immediate that upstream logic has already widened. For shift and rotate, its low 12 bits are a signed count. The second operand is the destination register's current value. Both outputs appear on the clock edge after issue.

Branch operations compare the stored status word against the selected condition and pulse `branch_taken`. Undefined operation codes pulse `illegal_op` and leave all state untouched. Fetch, memory and the register file sit outside this block.

The control decode is a flat classification of the operation code. An enumerated opcode type drives a `unique case` in the datapath. There are no sequencing states: every operation completes in a single cycle.

Top module: `alu_flag_unit`

## Requirements
- R1: ADD (code 4) registers result = {1'b0,opnd_a} + {1'b0,opnd_b}; bit 32 is the carry out.
- R2: MUL (code 5) registers the low 33 bits of the full 64-bit product of opnd_a and opnd_b.
- R3: CMP (code 6) registers result = {1'b0, ~opnd_a}.
- R4: SHF (code 7) treats opnd_a[11:0] as a two's-complement count.
  - A count of zero or more shifts {1'b0,opnd_b} right logically.
  - A negative count shifts {1'b0,opnd_b} left within 33 bits by its magnitude.
  - Any magnitude of 33 or more gives 0.
- R5: ROT (code 8) uses the same signed count and rotates opnd_b (32 bits) one position per count unit.
  - A positive count rotates right; result bit 32 is 0.
  - A negative count rotates left; result bit 32 equals the final result bit 0.
  - A zero count gives {1'b0,opnd_b}.
- R6: After ADD, MUL, CMP, SHF, ROT or LD, the status word is recomputed from the new 33-bit result r:
  - bit0 carry = r[32]
  - bit1 even = ~r[0]
  - bit2 parity = XOR of all 33 bits
  - bit3 zero = (r == 0) over all 33 bits
  - bit4 negative = r[31]
- R7: LD (code 2) registers result = {1'b0,opnd_a} and sets flags from it. STR (code 3) clears the status word to 0 and keeps the result.
- R8: BRA (code 1) pulses branch_taken for one cycle when the selected condition on the status word held at issue is true. The condition codes are 0 always, 1 carry, 2 even, 3 parity, 4 zero, 5 negative, and 6 to 15 never. BRA, NOP (0) and HLT (9) leave result and status unchanged.
- R9: Codes 10 to 15 pulse illegal_op for one cycle and leave result and status unchanged.
- R10: With issue low, result and status hold and both pulses are low.
- R11: While rst_n is low, result, status, branch_taken and illegal_op are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Operation present this cycle |
| opcode | input | 4 | Operation code |
| cond_sel | input | 4 | Branch condition selector |
| opnd_a | input | 32 | Source operand, or shift/rotate count in bits [11:0] |
| opnd_b | input | 32 | Destination operand value |
| result | output | 33 | Registered result, bit 32 is carry |
| status | output | 5 | Registered flags: carry, even, parity, zero, negative (bits 0..4) |
| branch_taken | output | 1 | One-cycle pulse, branch condition met |
| illegal_op | output | 1 | One-cycle pulse, undefined operation code |

## Verification
The embedded assertions watch several properties on every cycle. They check that add results match the operand sum one cycle later and that complement never sets carry. They also check that an illegal code or a taken branch leaves status untouched, and that an idle cycle changes nothing and raises no pulse.

Some behaviours appear only in the bench's directed scenarios. These are the direction and magnitude handling of signed shift and rotate counts, including the extremes near 33 and -2048. They also include the 33-bit zero flag after a carrying add, STR clearing the flags, and each branch condition code evaluated against a prepared status word. The bench checks all of these against a behavioural model that shifts and rotates one bit at a time.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int FLAG_W    = 5;
    localparam int FLG_CARRY = 0;
    localparam int FLG_EVEN  = 1;
    localparam int FLG_PAR   = 2;
    localparam int FLG_ZERO  = 3;
    localparam int FLG_NEG   = 4;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_BRA = 4'd1,
        OP_LD  = 4'd2,
        OP_STR = 4'd3,
        OP_ADD = 4'd4,
        OP_MUL = 4'd5,
        OP_CMP = 4'd6,
        OP_SHF = 4'd7,
        OP_ROT = 4'd8,
        OP_HLT = 4'd9
    } op_e;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'd0,
        CC_CARRY  = 4'd1,
        CC_EVEN   = 4'd2,
        CC_PAR    = 4'd3,
        CC_ZERO   = 4'd4,
        CC_NEG    = 4'd5
    } cond_e;

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W:0]   res,
    output logic              upd_res,
    output logic              upd_flags,
    output logic              clr_flags,
    output logic              is_branch,
    output logic              is_illegal
);
    localparam int RES_W = DATA_W + 1;

    logic [CNT_W-1:0]    cnt;
    logic                cnt_neg;
    logic [CNT_W-1:0]    cnt_mag;
    logic [CNT_W-1:0]    rot_k;
    logic [2*DATA_W-1:0] dbl_r;
    logic [2*DATA_W-1:0] dbl_l;
    logic [2*DATA_W-1:0] prod;
    logic [RES_W-1:0]    shf_res;
    logic [RES_W-1:0]    rot_res;

    // signed count: sign picks direction, magnitude picks distance
    always_comb begin
        cnt     = a_in[CNT_W-1:0];
        cnt_neg = cnt[CNT_W-1];
        cnt_mag = cnt_neg ? (~cnt + 1'b1) : cnt;
        rot_k   = cnt_mag % CNT_W'(DATA_W);
    end

    always_comb begin
        prod  = {{DATA_W{1'b0}}, a_in} * {{DATA_W{1'b0}}, b_in};
        dbl_r = {b_in, b_in} >> rot_k;
        dbl_l = {b_in, b_in} << rot_k;
        if (cnt_neg) shf_res = {1'b0, b_in} << cnt_mag;
        else         shf_res = {1'b0, b_in} >> cnt_mag;
        if (cnt_mag == '0)
            rot_res = {1'b0, b_in};
        else if (cnt_neg)
            rot_res = {dbl_l[DATA_W], dbl_l[2*DATA_W-1:DATA_W]};
        else
            rot_res = {1'b0, dbl_r[DATA_W-1:0]};
    end

    always_comb begin
        res        = '0;
        upd_res    = 1'b0;
        upd_flags  = 1'b0;
        clr_flags  = 1'b0;
        is_branch  = 1'b0;
        is_illegal = 1'b0;
        unique case (op_e'(op_code))
            OP_NOP, OP_HLT: ;
            OP_BRA: is_branch = 1'b1;
            OP_LD: begin
                res = {1'b0, a_in}; upd_res = 1'b1; upd_flags = 1'b1;
            end
            OP_STR: clr_flags = 1'b1;
            OP_ADD: begin
                res = {1'b0, a_in} + {1'b0, b_in}; upd_res = 1'b1; upd_flags = 1'b1;
            end
            OP_MUL: begin
                res = prod[DATA_W:0]; upd_res = 1'b1; upd_flags = 1'b1;
            end
            OP_CMP: begin
                res = {1'b0, ~a_in}; upd_res = 1'b1; upd_flags = 1'b1;
            end
            OP_SHF: begin
                res = shf_res; upd_res = 1'b1; upd_flags = 1'b1;
            end
            OP_ROT: begin
                res = rot_res; upd_res = 1'b1; upd_flags = 1'b1;
            end
            default: is_illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W:0]   res,
    output logic [FLAG_W-1:0] flags
);
    always_comb begin
        flags            = '0;
        flags[FLG_CARRY] = res[DATA_W];
        flags[FLG_EVEN]  = ~res[0];
        flags[FLG_PAR]   = ^res;
        flags[FLG_ZERO]  = ~(|res);
        flags[FLG_NEG]   = res[DATA_W-1];
    end
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
    import alu_flag_pkg::*;
(
    input  logic [FLAG_W-1:0] st,
    input  logic [3:0]        sel,
    output logic              take
);
    always_comb begin
        take = 1'b0;
        case (cond_e'(sel))
            CC_ALWAYS: take = 1'b1;
            CC_CARRY:  take = st[FLG_CARRY];
            CC_EVEN:   take = st[FLG_EVEN];
            CC_PAR:    take = st[FLG_PAR];
            CC_ZERO:   take = st[FLG_ZERO];
            CC_NEG:    take = st[FLG_NEG];
            default:   take = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [3:0]        opcode,
    input  logic [3:0]        cond_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W:0]   result,
    output logic [FLAG_W-1:0] status,
    output logic              branch_taken,
    output logic              illegal_op
);
    logic [DATA_W:0]   nxt_res;
    logic [FLAG_W-1:0] nxt_flags;
    logic              upd_res, upd_flags, clr_flags, is_branch, is_illegal;
    logic              cond_true;

    alu_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
        .op_code    (opcode),
        .a_in       (opnd_a),
        .b_in       (opnd_b),
        .res        (nxt_res),
        .upd_res    (upd_res),
        .upd_flags  (upd_flags),
        .clr_flags  (clr_flags),
        .is_branch  (is_branch),
        .is_illegal (is_illegal)
    );

    alu_flag_gen #(.DATA_W(DATA_W)) u_fg (
        .res   (nxt_res),
        .flags (nxt_flags)
    );

    alu_cond_eval u_ce (
        .st   (status),
        .sel  (cond_sel),
        .take (cond_true)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            status       <= '0;
            branch_taken <= 1'b0;
            illegal_op   <= 1'b0;
        end else begin
            branch_taken <= issue && is_branch && cond_true;
            illegal_op   <= issue && is_illegal;
            if (issue && upd_res)   result <= nxt_res;
            if (issue && upd_flags) status <= nxt_flags;
            else if (issue && clr_flags) status <= '0;
        end
    end

    // R1
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(issue && opcode == OP_ADD) |->
            result == $past({1'b0, opnd_a} + {1'b0, opnd_b}));

    // R3
    cmp_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(issue && opcode == OP_CMP) |-> !result[DATA_W] && !status[FLG_CARRY]);

    // R8
    branch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> $stable(status) && $stable(result) && !illegal_op);

    // R9
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> $stable(status) && $stable(result));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(issue) |-> $stable(result) && $stable(status) && !branch_taken && !illegal_op);

endmodule

// File: tb/alu_flag_unit_bench.sv
`timescale 1ns/1ps
module alu_flag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  opcode = '0;
    logic [3:0]  cond_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [32:0] result;
    logic [4:0]  status;
    logic        branch_taken, illegal_op;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [32:0] e_res = '0;
    logic [4:0]  e_st  = '0;
    logic        e_bt  = 1'b0;
    logic        e_ill = 1'b0;

    always #2.5 clk = ~clk;

    alu_flag_unit u_alu_flag_unit (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
        .cond_sel(cond_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .status(status),
        .branch_taken(branch_taken), .illegal_op(illegal_op)
    );

    function automatic logic [4:0] model_flags(input logic [32:0] r);
        logic [4:0] f;
        int ones = 0;
        for (int i = 0; i < 33; i++) if (r[i]) ones++;
        f[0] = r[32];
        f[1] = (r[0] == 1'b0);
        f[2] = (ones % 2) == 1;
        f[3] = (ones == 0);
        f[4] = r[31];
        return f;
    endfunction

    task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                         input int cc);
        logic [32:0] r;
        logic [31:0] v;
        logic        cy;
        longint unsigned p;
        int c;
        bit take;
        c = int'($signed(a[11:0]));
        e_bt  = 1'b0;
        e_ill = 1'b0;
        case (op)
            0, 9: ;
            1: begin
                case (cc)
                    0: take = 1;
                    1: take = e_st[0];
                    2: take = e_st[1];
                    3: take = e_st[2];
                    4: take = e_st[3];
                    5: take = e_st[4];
                    default: take = 0;
                endcase
                e_bt = take;
            end
            2: begin r = {1'b0, a}; e_res = r; e_st = model_flags(r); end
            3: e_st = '0;
            4: begin r = 33'(a) + 33'(b); e_res = r; e_st = model_flags(r); end
            5: begin
                p = longint'(a) * longint'(b);
                r = p[32:0]; e_res = r; e_st = model_flags(r);
            end
            6: begin r = {1'b0, ~a}; e_res = r; e_st = model_flags(r); end
            7: begin
                r = {1'b0, b};
                if (c >= 0) for (int i = 0; i < c; i++) r = r >> 1;
                else        for (int i = 0; i < -c; i++) r = r << 1;
                e_res = r; e_st = model_flags(r);
            end
            8: begin
                v = b; cy = 1'b0;
                if (c > 0) for (int i = 0; i < c; i++) v = {v[0], v[31:1]};
                else for (int i = 0; i < -c; i++) begin cy = v[31]; v = {v[30:0], v[31]}; end
                r = {cy, v}; e_res = r; e_st = model_flags(r);
            end
            default: e_ill = 1'b1;
        endcase
    endtask

    task automatic compare(input string tag);
        n_tests++;
        if (result !== e_res || status !== e_st || branch_taken !== e_bt ||
            illegal_op !== e_ill) begin
            n_fail++;
            $display("FAIL %s: act res=%h st=%b bt=%b ill=%b exp res=%h st=%b bt=%b ill=%b",
                     tag, result, status, branch_taken, illegal_op,
                     e_res, e_st, e_bt, e_ill);
        end
    endtask

    task automatic run(input int op, input logic [31:0] a, input logic [31:0] b,
                       input int cc, input string tag);
        @(negedge clk);
        issue = 1'b1; opcode = 4'(op); opnd_a = a; opnd_b = b; cond_sel = 4'(cc);
        model(op, a, b, cc);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        issue = 1'b0; opcode = 4'd4; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1;
        e_bt = 1'b0; e_ill = 1'b0;
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: act running exp finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R11 reset, even with an operation presented
        issue = 1'b1; opcode = 4'd6; opnd_a = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        e_res = '0; e_st = '0; e_bt = 0; e_ill = 0;
        compare("R11 reset");
        @(negedge clk);
        issue = 1'b0; rst_n = 1'b1;
        @(posedge clk); #1;
        compare("R11 after release");

        run(4, 32'd5, 32'd7, 0, "R1 add small");
        run(4, 32'hFFFF_FFFF, 32'd1, 0, "R1 R6 add carry zero33");
        run(1, 0, 0, 1, "R8 branch carry");
        run(1, 0, 0, 4, "R8 branch zero not set");
        run(1, 0, 0, 2, "R8 branch even");
        run(1, 0, 0, 3, "R8 branch parity");
        run(1, 0, 0, 5, "R8 branch negative");
        run(1, 0, 0, 0, "R8 branch always");
        run(1, 0, 0, 6, "R8 branch code 6");
        run(1, 0, 0, 15, "R8 branch code 15");
        run(4, 32'h8000_0000, 32'h7FFF_FFFF, 0, "R1 R6 add negative");
        run(5, 32'h1234_5678, 32'h9ABC_DEF0, 0, "R2 mul large");
        run(5, 32'h8000_0000, 32'd2, 0, "R2 mul carry only");
        run(5, 32'd3, 32'd0, 0, "R2 mul zero");
        run(6, 32'h0F0F_0000, 0, 0, "R3 complement");
        run(6, 32'hFFFF_FFFF, 0, 0, "R3 complement to zero");
        run(7, 32'd4, 32'hF000_00F0, 0, "R4 shift right 4");
        run(7, 32'hFFF, 32'h8000_0001, 0, "R4 shift left 1 carry");
        run(7, 32'h0, 32'hDEAD_BEEF, 0, "R4 shift zero count");
        run(7, 32'hFDF, 32'hFFFF_FFFF, 0, "R4 shift left 33");
        run(7, 32'd40, 32'hFFFF_FFFF, 0, "R4 shift right 40");
        run(7, 32'h800, 32'hFFFF_FFFF, 0, "R4 shift left 2048");
        run(7, 32'hFFFF_F000 | 32'hFE0, 32'h0000_0001, 0, "R4 shift upper bits ignored");
        run(8, 32'd1, 32'h0000_0003, 0, "R5 rotate right 1");
        run(8, 32'hFFF, 32'h8000_0002, 0, "R5 rotate left 1");
        run(8, 32'hFE0, 32'h1234_5679, 0, "R5 rotate left 32");
        run(8, 32'd33, 32'h0000_0001, 0, "R5 rotate right 33");
        run(8, 32'd0, 32'hCAFE_F00D, 0, "R5 rotate zero count");
        run(8, 32'hFFC, 32'hF000_0000, 0, "R5 rotate left 4");
        run(2, 32'd0, 32'h5555_5555, 0, "R7 R6 load zero");
        run(1, 0, 0, 4, "R8 branch zero taken");
        run(2, 32'h0000_0FFF, 0, 0, "R7 load imm");
        run(3, 32'hAAAA_AAAA, 0, 0, "R7 store clears flags");
        run(1, 0, 0, 2, "R7 R8 branch after store");
        run(4, 32'h8000_0000, 32'd1, 0, "R1 set flags");
        run(0, 32'h1, 32'h1, 0, "R8 nop no change");
        run(9, 32'h1, 32'h1, 0, "R8 halt no change");
        run(10, 32'h1, 32'h1, 0, "R9 illegal 10");
        run(15, 32'hFFFF_FFFF, 32'h1, 0, "R9 illegal 15");
        idle("R10 idle");
        idle("R10 idle again");
        run(6, 32'h1, 0, 0, "R3 after idle");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule